// File: doc/BRIEF.md
# Programmable Binary Tap Timer

A synchronous timer around a 16-bit binary counter that advances once per system clock cycle in which the tick input is high. The tick stands in for a slow oscillator. The output comes from one of four counter stages chosen by two select inputs, and a polarity input can invert it. The block has two modes. In recycle mode it divides the tick rate by a power of two. In single-transition mode it acts as a one-shot delay: after a master reset the output changes level once, after a chosen number of ticks, and then stays there.

The power-on reset `rst_ni` always initialises the registers. The auto-reset disable strap decides what follows. When the strap is low, counting starts with the first tick after power-up. When it is high, the counter stays parked until a master reset pulse has been seen. A master reset clears the count and the held level, and counting is suspended while it is high.

Top module: `tap_timer`

## Requirements
- R1: The counter advances by exactly one, wrapping modulo 65536, on each clock edge where `tick_i` is high, no reset is active, the counter is not parked and no held level is frozen. Otherwise it keeps its value.
- R2: The stage is chosen by `{sel_a_i, sel_b_i}`: 2'b00 selects N=13, 2'b01 selects N=10, 2'b10 selects N=8 and 2'b11 selects N=16. The output is drawn from zero-based counter bit N-1.
- R3: With `recycle_i`=1 the output is a square wave with a period of 2^N ticks. It sits at its starting level for the first 2^(N-1) ticks after reset and then toggles every 2^(N-1) ticks.
- R4: With `recycle_i`=0 the output changes level exactly once. The change happens on the edge that takes the 2^(N-1)-th tick after a master reset.
- R5: Once the level has changed in single-transition mode, it holds until a master reset or until `recycle_i` goes high. Further ticks are ignored and the counter is frozen.
- R6: Raising `recycle_i` releases the held level. The output then follows the selected counter bit, continuing from the frozen count.
- R7: `invert_i`=0 makes the output start low after reset. `invert_i`=1 inverts the whole output sequence, so the output starts high.
- R8: `rst_ni` low asynchronously clears the counter, the held level and the arm state. With `auto_dis_i`=0, counting starts at the first tick after release.
- R9: With `auto_dis_i`=1, ticks after power-on reset have no effect until `mreset_i` has been high for at least one clock and then returns low.
- R10: `mreset_i` is synchronous and active high. While it is high the counter is zero on the following edge and no tick is counted.
- R11: A change of `{sel_a_i, sel_b_i}` moves the output to the newly selected stage at once, without clearing the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| auto_dis_i | input | 1 | 1: no start after power-on; wait for a master reset pulse |
| mreset_i | input | 1 | Synchronous active-high master reset |
| tick_i | input | 1 | Count enable, one count per clock while high |
| sel_a_i | input | 1 | Stage select, upper bit |
| sel_b_i | input | 1 | Stage select, lower bit |
| recycle_i | input | 1 | 1: recycle (divider) mode; 0: single-transition mode |
| invert_i | input | 1 | Output polarity, 1 inverts |
| timer_o | output | 1 | Timer output |

## Verification
Every state change lands on the clock edge that samples the tick or reset, and the output is a combinational function of the registered state and the select, mode and polarity inputs. A tick sampled at one edge is therefore due at the output within that same cycle, while changes to select, mode or polarity show up without any wait. The bench drives its inputs just after the falling edge and compares the output one nanosecond after the next falling edge against a behavioural model updated on the rising edge, so each result is sampled exactly one edge after its stimulus. Directed checks at the tick counts 2^(N-1)-1 and 2^(N-1) pin down the transition edge for each stage.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  localparam int CNT_W    = 16;
  localparam int NUM_TAPS = 4;

  // stage number for each select code {A,B}
  function automatic int tap_stage(input int code);
    case (code)
      0:       return 13;
      1:       return 10;
      2:       return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/tap_counter.sv
module tap_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nx_o
);
  logic [W-1:0] cnt_q;

  assign cnt_nx_o = cnt_q + W'(1);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_nx_o;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> cnt_q == W'($past(cnt_q) + W'(1))) else $error("step"); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q)) else $error("hold"); // R1
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0) else $error("clr"); // R10
endmodule

// File: rtl/tap_select.sv
module tap_select
  import tap_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic [W-1:0] cnt_i,
  input  logic [1:0]   sel_i,
  output logic         bit_o
);
  logic [NUM_TAPS-1:0] taps;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int IDX = tap_stage(i) - 1;
    assign taps[i] = cnt_i[IDX];
  end

  assign bit_o = taps[sel_i];
endmodule

// File: rtl/oneshot_latch.sv
module oneshot_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (clr_i)  q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
  end

  assign q_o = q_q;

  AST_LATCH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q && !clr_i) |=> q_q) else $error("keep"); // R5
  AST_LATCH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_q) else $error("clear"); // R6
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_dis_i,
  input  logic mreset_i,
  input  logic tick_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic recycle_i,
  input  logic invert_i,
  output logic timer_o
);
  logic [1:0]   sel;
  logic [W-1:0] cnt_q, cnt_nx;
  logic         cur_bit, nx_bit;
  logic         arm_q, run, hold, cnt_en, rise, latch_q;

  assign sel = {sel_a_i, sel_b_i};

  // arm once a master reset has been seen; needed only when auto start is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_q <= 1'b0;
    else if (mreset_i)  arm_q <= 1'b1;
  end

  assign run    = arm_q | ~auto_dis_i;
  assign hold   = latch_q & ~recycle_i;
  assign cnt_en = tick_i & run & ~hold & ~mreset_i;

  tap_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mreset_i),
    .en_i     (cnt_en),
    .cnt_o    (cnt_q),
    .cnt_nx_o (cnt_nx)
  );

  tap_select #(.W(W)) u_sel_cur (.cnt_i(cnt_q),  .sel_i(sel), .bit_o(cur_bit));
  tap_select #(.W(W)) u_sel_nx  (.cnt_i(cnt_nx), .sel_i(sel), .bit_o(nx_bit));

  assign rise = cnt_en & ~cur_bit & nx_bit;

  oneshot_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mreset_i | recycle_i),
    .set_i  (rise & ~recycle_i),
    .q_o    (latch_q)
  );

  assign timer_o = (recycle_i ? cur_bit : latch_q) ^ invert_i;

  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !recycle_i && !mreset_i) |=> $stable(cnt_q)) else $error("frozen"); // R5
  AST_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_dis_i && !arm_q && !mreset_i) |=> $stable(cnt_q)) else $error("parked"); // R9
  AST_MRESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (!latch_q && cnt_q == '0)) else $error("mreset"); // R10
  AST_MODE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recycle_i |=> !latch_q) else $error("release"); // R6
endmodule

// File: tb/tap_timer_bench.sv
module tap_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_dis = 1'b0, mres = 1'b0, tick = 1'b0;
  logic a = 1'b0, b = 1'b0, mode = 1'b0, inv = 1'b0;
  logic timer;

  int checks = 0, failures = 0;
  string cur_req = "R8";
  bit done = 0;

  int m_cnt = 0;
  bit m_lat = 0, m_arm = 0, m_live = 0, m_old = 0;
  int m_b = 0;

  always #5 clk = ~clk;

  tap_timer u_tap_timer (
    .clk_i(clk), .rst_ni(rst_n), .auto_dis_i(auto_dis), .mreset_i(mres),
    .tick_i(tick), .sel_a_i(a), .sel_b_i(b), .recycle_i(mode),
    .invert_i(inv), .timer_o(timer)
  );

  function automatic int n_of(input logic sa, input logic sb);
    case ({sa, sb})
      2'b00: return 13;
      2'b01: return 10;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lat = 0; m_arm = 0;
    end else if (mres) begin
      m_cnt = 0; m_lat = 0; m_arm = 1;
    end else begin
      m_live = tick && (m_arm || !auto_dis) && !(m_lat && !mode);
      if (mode) m_lat = 0;
      if (m_live) begin
        m_b   = n_of(a, b) - 1;
        m_old = ((m_cnt >> m_b) & 1) != 0;
        m_cnt = (m_cnt + 1) & 65535;
        if (!mode && !m_old && (((m_cnt >> m_b) & 1) != 0)) m_lat = 1;
      end
    end
  end

  function automatic logic model_out();
    logic lv;
    lv = mode ? (((m_cnt >> (n_of(a, b) - 1)) & 1) != 0) : m_lat;
    return lv ^ inv;
  endfunction

  task automatic check_eq(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // compare then drive the next inputs
  task automatic step(input logic t);
    @(negedge clk);
    #1;
    check_eq(timer, model_out(), cur_req);
    tick = t;
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      for (int g = 0; g < gap; g++) step(1'b0);
    end
  endtask

  task automatic pulse_mreset();
    @(negedge clk); #1; mres = 1'b1; tick = 1'b1;
    @(negedge clk); #1; mres = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_eq(timer, 1'b0, "R8");
    inv = 1'b1; #1;
    check_eq(timer, 1'b1, "R7");
    inv = 1'b0;
    rst_n = 1'b1;

    // R1 R3: N=8 recycle, tick every cycle from power-on
    cur_req = "R3"; a = 1'b1; b = 1'b0; mode = 1'b1;
    run_ticks(127, 0);
    step(1'b1); check_eq(timer, 1'b0, "R3");
    step(1'b0); check_eq(timer, 1'b1, "R3");
    cur_req = "R1";
    run_ticks(600, 0);

    // R11: select change without clearing
    cur_req = "R11";
    a = 1'b0; b = 1'b1;
    run_ticks(700, 1);
    a = 1'b1; b = 1'b0;
    run_ticks(50, 0);

    // R4 R5: N=10 single transition, sparse ticks
    cur_req = "R4"; mode = 1'b0; a = 1'b0; b = 1'b1;
    pulse_mreset();
    run_ticks(511, 1);
    step(1'b0); check_eq(timer, 1'b0, "R4");
    run_ticks(1, 0);
    step(1'b0); check_eq(timer, 1'b1, "R4");
    cur_req = "R5";
    run_ticks(1500, 0);
    step(1'b0); check_eq(timer, 1'b1, "R5");

    // R6: release from frozen count 512
    cur_req = "R6"; mode = 1'b1;
    step(1'b0); check_eq(timer, 1'b1, "R6");
    run_ticks(511, 0);
    step(1'b0); check_eq(timer, 1'b1, "R6");
    run_ticks(1, 0);
    step(1'b0); check_eq(timer, 1'b0, "R6");

    // R7: inverted single transition, N=8
    cur_req = "R7"; inv = 1'b1; mode = 1'b0; a = 1'b1; b = 1'b0;
    pulse_mreset();
    step(1'b0); check_eq(timer, 1'b1, "R7");
    run_ticks(300, 0);
    step(1'b0); check_eq(timer, 1'b0, "R7");
    inv = 1'b0;

    // R2: N=13 and N=16 single transitions
    cur_req = "R2"; a = 1'b0; b = 1'b0;
    pulse_mreset();
    run_ticks(4095, 0);
    step(1'b0); check_eq(timer, 1'b0, "R2");
    run_ticks(1, 0);
    step(1'b0); check_eq(timer, 1'b1, "R2");
    a = 1'b1; b = 1'b1;
    pulse_mreset();
    run_ticks(32767, 0);
    step(1'b0); check_eq(timer, 1'b0, "R2");
    run_ticks(1, 0);
    step(1'b0); check_eq(timer, 1'b1, "R2");

    // R10: held master reset with ticks
    cur_req = "R10"; mode = 1'b1; a = 1'b1; b = 1'b0;
    run_ticks(200, 0);
    @(negedge clk); #1; mres = 1'b1;
    run_ticks(20, 0);
    @(negedge clk); #1; mres = 1'b0;
    step(1'b0); check_eq(timer, 1'b0, "R10");
    run_ticks(300, 0);

    // R9: auto start disabled, parked until master reset pulse
    cur_req = "R9";
    @(negedge clk); #1; rst_n = 1'b0; auto_dis = 1'b1;
    @(negedge clk); #1; rst_n = 1'b1;
    run_ticks(200, 0);
    step(1'b0); check_eq(timer, 1'b0, "R9");
    pulse_mreset();
    run_ticks(127, 0);
    step(1'b0); check_eq(timer, 1'b0, "R9");
    run_ticks(1, 0);
    step(1'b0); check_eq(timer, 1'b1, "R9");
    run_ticks(300, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule